// File: doc/BRIEF.md
# Replacement-Interval Memory Demand Estimator

One copy of this block sits beside each private second-level cache and turns the spacing of that cache's replacements into a single demand figure. A counter measures how many cycles have passed since the last replacement. Each replacement folds that count into a history register and restarts the counter. A small history value means replacements arrive close together, so the attached processor is under heavy memory pressure. A large value means the processor needs little memory.

The history value is driven out so that peer caches can read it. It also feeds a comparator. The comparator takes a history value sent by a peer and a multiplier, and reports whether that peer's demand is lower than the local demand by at least that multiplier. Logic outside the block uses this result when it decides where an evicted line may be placed. Choosing the peer is not part of this block.

Top module: `demand_estimator`

## Requirements
- R1: After reset the history output reads 255 and the interval counter holds 0. A replacement on the first clock edge after reset therefore leaves history at 127.
- R2: On every clock edge without a replacement, the interval counter goes up by one.
- R3: The interval counter stops at 255 and never wraps. Any number of idle cycles at or above 255 gives the same result at the next replacement as exactly 255 idle cycles.
- R4: On a clock edge with `replStrobe` high, the history becomes floor((old history + interval count) / 2). The sum is formed at full width before the halving.
- R5: The same replacement edge clears the interval counter to 0. Two replacements on consecutive edges therefore use a count of 0 for the second one.
- R6: On edges without a replacement, the history output does not change.
- R7: `peerLower` is 1 exactly when `peerHistory` is strictly greater than `localHistory` multiplied by `factor`. It is combinational from the current inputs and history.
- R8: The product `localHistory * factor` is kept at full width and never truncated. A factor of 0 makes any nonzero peer history qualify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| replStrobe | input | 1 | High for one cycle per replacement in the local cache |
| peerHistory | input | 8 | History value received from a peer cache |
| factor | input | 4 | Unsigned multiplier for the demand comparison |
| localHistory | output | 8 | Current local history (demand estimate) |
| peerLower | output | 1 | Peer demand is lower by at least the factor |

## Verification
The bound checker checks every cycle that the history resets to 255 with a cleared counter, that the counter steps by one or stays at 255, that each replacement produces the halved sum and clears the counter, and that the history holds between replacements. It also checks that a positive comparison with a nonzero factor always implies a peer history above the local one. Only the bench's scenarios can show that the exact comparison boundaries are right: the equal case, a product beyond 8 bits, and a zero factor. They also show that long idle stretches give the same result as exactly 255 idle cycles at the next replacement.

// File: rtl/demand_est_pkg.sv
package demand_est_pkg;
  // Strobes from the control module to the datapath
  typedef struct packed {
    logic incCnt;    // advance interval counter
    logic clearCnt;  // restart interval counter
    logic foldHist;  // merge count into history
  } demandStrobes_t;
endpackage

// File: rtl/demand_ctrl.sv
module demand_ctrl
  import demand_est_pkg::*;
(
  input  logic           replStrobe,
  input  logic           cntSat,
  output demandStrobes_t strobes
);
  always_comb begin
    strobes          = '0;
    strobes.foldHist = replStrobe;
    strobes.clearCnt = replStrobe;
    strobes.incCnt   = !replStrobe && !cntSat;
  end
endmodule

// File: rtl/demand_datapath.sv
module demand_datapath
  import demand_est_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  demandStrobes_t   strobes,
  output logic [CNT_W-1:0] intervalCnt,
  output logic [CNT_W-1:0] history,
  output logic             cntSat
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W:0]   sumWide;
  logic [CNT_W-1:0] histNext;

  assign cntSat   = (intervalCnt == CNT_MAX);
  assign sumWide  = {1'b0, history} + {1'b0, intervalCnt};
  assign histNext = sumWide[CNT_W:1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intervalCnt <= '0;
    end else if (strobes.clearCnt) begin
      intervalCnt <= '0;
    end else if (strobes.incCnt) begin
      intervalCnt <= intervalCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      history <= CNT_MAX;
    end else if (strobes.foldHist) begin
      history <= histNext;
    end
  end
endmodule

// File: rtl/demand_cmp.sv
module demand_cmp #(
  parameter int HIST_W   = 8,
  parameter int FACTOR_W = 4
) (
  input  logic [HIST_W-1:0]   localHist,
  input  logic [HIST_W-1:0]   peerHist,
  input  logic [FACTOR_W-1:0] factor,
  output logic                peerLower
);
  localparam int PROD_W = HIST_W + FACTOR_W;

  logic [PROD_W-1:0] scaledLocal;
  logic [PROD_W-1:0] peerWide;

  assign scaledLocal = PROD_W'(localHist) * PROD_W'(factor);
  assign peerWide    = PROD_W'(peerHist);
  assign peerLower   = (peerWide > scaledLocal);
endmodule

// File: rtl/demand_estimator.sv
module demand_estimator
  import demand_est_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int FACTOR_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                replStrobe,
  input  logic [CNT_W-1:0]    peerHistory,
  input  logic [FACTOR_W-1:0] factor,
  output logic [CNT_W-1:0]    localHistory,
  output logic                peerLower
);
  demandStrobes_t   strobes;
  logic             cntSat;
  logic [CNT_W-1:0] intervalCnt;

  demand_ctrl ctrl_i (
    .replStrobe(replStrobe),
    .cntSat    (cntSat),
    .strobes   (strobes)
  );

  demand_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .intervalCnt(intervalCnt),
    .history    (localHistory),
    .cntSat     (cntSat)
  );

  demand_cmp #(.HIST_W(CNT_W), .FACTOR_W(FACTOR_W)) cmp_i (
    .localHist(localHistory),
    .peerHist (peerHistory),
    .factor   (factor),
    .peerLower(peerLower)
  );
endmodule

// File: rtl/demand_estimator_chk.sv
module demand_estimator_chk #(
  parameter int CNT_W    = 8,
  parameter int FACTOR_W = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                replStrobe,
  input logic [CNT_W-1:0]    peerHistory,
  input logic [FACTOR_W-1:0] factor,
  input logic [CNT_W-1:0]    localHistory,
  input logic                peerLower,
  input logic [CNT_W-1:0]    intervalCnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R1: first cycle out of reset shows the reset values
  p_reset_vals_r1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (localHistory == CNT_MAX && intervalCnt == '0));

  // R2: one step per idle cycle below the ceiling
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(replStrobe) && $past(intervalCnt) != CNT_MAX)
      |-> intervalCnt == $past(intervalCnt) + 1'b1);

  // R3: ceiling holds
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(replStrobe) && $past(intervalCnt) == CNT_MAX)
      |-> intervalCnt == CNT_MAX);

  // R4: fold of old history and interval
  p_fold_avg_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(replStrobe))
      |-> localHistory == CNT_W'(({1'b0, $past(localHistory)} + {1'b0, $past(intervalCnt)}) >> 1));

  // R5: counter restarts after a replacement
  p_cnt_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(replStrobe)) |-> intervalCnt == '0);

  // R6: history holds without replacement
  p_hist_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(replStrobe)) |-> $stable(localHistory));

  // R7: a nonzero factor never lets a peer at or below local history qualify
  p_cmp_order_r7: assert property (@(posedge clk) disable iff (!rstN)
    (factor != '0 && peerLower) |-> peerHistory > localHistory);
endmodule

bind demand_estimator demand_estimator_chk #(.CNT_W(CNT_W), .FACTOR_W(FACTOR_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .replStrobe  (replStrobe),
  .peerHistory (peerHistory),
  .factor      (factor),
  .localHistory(localHistory),
  .peerLower   (peerLower),
  .intervalCnt (intervalCnt)
);

// File: tb/demand_estimator_tb_top.sv
module demand_estimator_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       replStrobe = 1'b0;
  logic [7:0] peerHistory = '0;
  logic [3:0] factor = '0;
  logic [7:0] localHistory;
  logic       peerLower;

  int testsRun = 0;
  int testsFailed = 0;
  int expHist = 255;
  int expCnt = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  demand_estimator dut_i (
    .clk(clk), .rstN(rstN), .replStrobe(replStrobe),
    .peerHistory(peerHistory), .factor(factor),
    .localHistory(localHistory), .peerLower(peerLower)
  );

  task automatic checkVal(input int actual, input int expected, input string req);
    testsRun++;
    if (actual != expected) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0;
    replStrobe = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expHist = 255;
    expCnt = 0;
  endtask

  // idle cycles; history must not move (R6), count tracked for R2/R3
  task automatic idle(input int n, input bool_chk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      expCnt = (expCnt < 255) ? expCnt + 1 : 255;
      if (bool_chk != 0) checkVal(int'(localHistory), expHist, "R6 hold");
    end
  endtask

  // one replacement edge, R4 fold and R5 restart
  task automatic replace(input string req);
    replStrobe = 1'b1;
    @(negedge clk);
    replStrobe = 1'b0;
    expHist = (expHist + expCnt) / 2;
    expCnt = 0;
    checkVal(int'(localHistory), expHist, req);
  endtask

  task automatic testReset();
    applyReset();
    checkVal(int'(localHistory), 255, "R1 history");
    replace("R1 count zero");
    checkVal(int'(localHistory), 127, "R1 first fold");
  endtask

  task automatic testCountAndFold();
    idle(10, 1);
    replace("R2 R4 after 10 idle");
    checkVal(int'(localHistory), 68, "R4 value");
    idle(3, 0);
    replace("R4 after 3 idle");
  endtask

  task automatic testBackToBack();
    replace("R5 first");
    replace("R5 second uses count 0");
    replace("R5 third uses count 0");
  endtask

  task automatic testHold();
    idle(40, 1);
    replace("R4 after 40 idle");
  endtask

  task automatic testSaturate();
    idle(300, 0);
    replace("R3 saturated at 255");
    idle(255, 0);
    replace("R3 exactly 255");
    idle(600, 0);
    replace("R3 long idle");
  endtask

  task automatic cmpCase(input int peer, input int fac, input int expected, input string req);
    peerHistory = 8'(peer);
    factor = 4'(fac);
    #1;
    checkVal(int'(peerLower), expected, req);
  endtask

  task automatic testCompare();
    applyReset();
    @(negedge clk);
    expCnt = 1;
    cmpCase(255, 1, 0, "R7 equal not greater");
    cmpCase(254, 1, 0, "R7 smaller peer");
    cmpCase(0, 0, 0, "R8 factor0 zero peer");
    cmpCase(1, 0, 1, "R8 factor0 nonzero peer");
    // make history 127
    applyReset();
    replace("R1 fold to 127");
    cmpCase(254, 2, 0, "R7 equal at factor 2");
    cmpCase(255, 2, 1, "R7 above at factor 2");
    cmpCase(128, 1, 1, "R7 just above factor 1");
    cmpCase(127, 1, 0, "R7 equal factor 1");
    cmpCase(255, 3, 0, "R8 wide product 381");
    cmpCase(255, 15, 0, "R8 wide product 1905");
    peerHistory = '0;
    factor = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    testReset();
    testCountAndFold();
    testBackToBack();
    testHold();
    testSaturate();
    testCompare();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule